// File: doc/BRIEF.md
# Paired FIFO Status and Pulse-Reset Control

This block holds two word-wide FIFOs of equal, parameterized depth. The outbound FIFO is filled by the local side and drained by the bus side. The inbound FIFO is filled by the bus side and drained by the local side. Each FIFO reports empty and full. Each also reports a threshold flag, and the two thresholds look in opposite directions. The outbound flag says that at least four words are waiting to be drained. The inbound flag says that at least four slots are free to be filled.

A control register sits next to the FIFOs. Three of its bits are strobes: writing a 1 to one of them produces a one-cycle internal pulse, and nothing needs to be written back. One strobe clears the outbound FIFO. One clears the inbound FIFO. The third clears a small vector of mailbox-full flags, which external inputs set one bit at a time. Software never reads these strobe bits back; they always return zero. One further bit is an ordinary read/write enable that tells the bus-master logic whether transfer counts apply.

Top module: `dual_fifo_flags`

## Requirements
- R1: Words pushed into a FIFO leave it in push order. Each FIFO is show-ahead: while it is not empty, its read-data port presents the oldest word, and a pop moves on to the next one.
- R2: A FIFO's empty flag is 1 exactly when it holds zero words. Its full flag is 1 exactly when it holds DEPTH words. Both flags update in the cycle after the push or pop.
- R3: `ob_four` is 1 exactly when the outbound FIFO holds 4 or more words.
- R4: `ib_four` is 1 exactly when the inbound FIFO has 4 or more free slots. With the default depth of 8 it is 1 after reset and goes to 0 on the fifth word.
- R5: A push into a full FIFO is ignored, and so is a pop from an empty FIFO. The stored words and the flags are left unchanged.
- R6: A control write with bit 26 set empties the outbound FIFO in the next cycle: `ob_empty`=1, `ob_full`=0, `ob_four`=0, and both pointers return to slot 0. This clear takes priority over a push or pop in the same cycle. The inbound FIFO is unaffected.
- R7: A control write with bit 25 set empties the inbound FIFO in the next cycle: `ib_empty`=1, `ib_full`=0, `ib_four`=1. This clear takes priority over a push or pop in the same cycle.
- R8: A 1 on `mbox_set[i]` sets `mbox_full[i]` from the next cycle. A control write with bit 27 set clears all mailbox flags in the next cycle, and this clear wins over a set in the same cycle.
- R9: Bit 28 is a read/write bit. It holds the last value written, shows on `ctl_rdata[28]`, and drives `xfer_cnt_en`.
- R10: Bits 27:25 are write-only strobes and read as 0. All other bits of `ctl_rdata` read as 0.
- R11: After reset, both FIFOs are empty, `ob_four`=0, `ib_four`=1, all mailbox flags are 0, and bit 28 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read value |
| xfer_cnt_en | output | 1 | Transfer-count enable (bit 28) |
| ob_push | input | 1 | Outbound push (local side) |
| ob_wdata | input | 32 | Outbound write word |
| ob_pop | input | 1 | Outbound pop (bus side) |
| ob_rdata | output | 32 | Oldest outbound word |
| ob_empty | output | 1 | Outbound empty |
| ob_full | output | 1 | Outbound full |
| ob_four | output | 1 | Outbound holds at least 4 words |
| ib_push | input | 1 | Inbound push (bus side) |
| ib_wdata | input | 32 | Inbound write word |
| ib_pop | input | 1 | Inbound pop (local side) |
| ib_rdata | output | 32 | Oldest inbound word |
| ib_empty | output | 1 | Inbound empty |
| ib_full | output | 1 | Inbound full |
| ib_four | output | 1 | Inbound has at least 4 free slots |
| mbox_set | input | 4 | Per-flag mailbox set pulses |
| mbox_full | output | 4 | Mailbox full flags |

## Verification
The assertions assume that the strobes and `ctl_wdata` carry known values at every rising edge. They also assume that a push into a full FIFO, or a pop from an empty one, can arrive together with the opposite operation. For that reason, the overflow and underflow properties only apply when the opposite operation is idle and no clear strobe is present. The bench changes its inputs only on falling edges and returns every strobe to 0 after one cycle, so each push, pop or control write counts exactly once. Its cases deliberately put a clear strobe in the same cycle as a push, a pop or a mailbox set, to exercise the priority rules.

// File: rtl/dual_fifo_flags.sv
module dual_fifo_flags #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 8,
  parameter int THRESH     = 4,
  parameter int MBOX_N     = 4,
  parameter int CTL_W      = 32,
  parameter int IB_CLR_BIT = 25,
  parameter int OB_CLR_BIT = 26,
  parameter int MB_CLR_BIT = 27,
  parameter int XFER_BIT   = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic              xfer_cnt_en,
  input  logic              ob_push,
  input  logic [DATA_W-1:0] ob_wdata,
  input  logic              ob_pop,
  output logic [DATA_W-1:0] ob_rdata,
  output logic              ob_empty,
  output logic              ob_full,
  output logic              ob_four,
  input  logic              ib_push,
  input  logic [DATA_W-1:0] ib_wdata,
  input  logic              ib_pop,
  output logic [DATA_W-1:0] ib_rdata,
  output logic              ib_empty,
  output logic              ib_full,
  output logic              ib_four,
  input  logic [MBOX_N-1:0] mbox_set,
  output logic [MBOX_N-1:0] mbox_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] THR_CNT  = CW'(THRESH);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  // index 0 = outbound, index 1 = inbound
  logic [1:0]        push_v, pop_v, clr_v, empty_v, full_v;
  logic [DATA_W-1:0] wd_v [2];
  logic [DATA_W-1:0] rd_v [2];
  logic [CW-1:0]     cnt  [2];
  logic              mb_clr;
  logic              ctl_unused;

  assign push_v = {ib_push, ob_push};
  assign pop_v  = {ib_pop, ob_pop};
  assign clr_v  = {ctl_wr & ctl_wdata[IB_CLR_BIT], ctl_wr & ctl_wdata[OB_CLR_BIT]};
  assign mb_clr = ctl_wr & ctl_wdata[MB_CLR_BIT];
  assign wd_v[0] = ob_wdata;
  assign wd_v[1] = ib_wdata;
  assign ctl_unused = ^ctl_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_push, do_pop;

    assign do_push = push_v[g] && (cnt[g] != FULL_CNT);
    assign do_pop  = pop_v[g] && (cnt[g] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
        cnt[g] <= '0;
      end else if (clr_v[g]) begin
        wp <= '0;
        rp <= '0;
        cnt[g] <= '0;
      end else begin
        if (do_push) wp <= (wp == LAST_SLOT) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == LAST_SLOT) ? '0 : rp + 1'b1;
        cnt[g] <= cnt[g] + CW'(do_push) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk) begin
      if (do_push && !clr_v[g]) mem[wp] <= wd_v[g];
    end

    assign rd_v[g]    = mem[rp];
    assign empty_v[g] = (cnt[g] == '0);
    assign full_v[g]  = (cnt[g] == FULL_CNT);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_v[g] && push_v[g] && !pop_v[g] && !clr_v[g]) |=> full_v[g]);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_v[g] && pop_v[g] && !push_v[g] && !clr_v[g]) |=> empty_v[g]);
  end

  assign ob_rdata = rd_v[0];
  assign ib_rdata = rd_v[1];
  assign ob_empty = empty_v[0];
  assign ob_full  = full_v[0];
  assign ib_empty = empty_v[1];
  assign ib_full  = full_v[1];
  assign ob_four  = cnt[0] >= THR_CNT;
  assign ib_four  = (FULL_CNT - cnt[1]) >= THR_CNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mbox_full <= '0;
    else if (mb_clr) mbox_full <= '0;
    else             mbox_full <= mbox_full | mbox_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      xfer_cnt_en <= 1'b0;
    else if (ctl_wr) xfer_cnt_en <= ctl_wdata[XFER_BIT];
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[XFER_BIT] = xfer_cnt_en;
  end

  assert_ob_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[0] |=> (ob_empty && !ob_full && !ob_four));
  assert_ib_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[1] |=> (ib_empty && !ib_full && ib_four));
  assert_mbox_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mb_clr |=> (mbox_full == '0));
  assert_xfer_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata[XFER_BIT] == $past(ctl_wdata[XFER_BIT])));
  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ob_empty && ob_full) && !(ib_empty && ib_full));
endmodule

// File: tb/tb_dual_fifo_flags.sv
module tb_dual_fifo_flags;
  localparam int DEPTH = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        xfer_cnt_en;
  logic        ob_push = 1'b0, ob_pop = 1'b0, ib_push = 1'b0, ib_pop = 1'b0;
  logic [31:0] ob_wdata = '0, ib_wdata = '0;
  logic [31:0] ob_rdata, ib_rdata;
  logic        ob_empty, ob_full, ob_four, ib_empty, ib_full, ib_four;
  logic [3:0]  mbox_set = '0;
  logic [3:0]  mbox_full;
  int          n_checks = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  dual_fifo_flags dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .xfer_cnt_en(xfer_cnt_en),
    .ob_push(ob_push), .ob_wdata(ob_wdata), .ob_pop(ob_pop), .ob_rdata(ob_rdata),
    .ob_empty(ob_empty), .ob_full(ob_full), .ob_four(ob_four),
    .ib_push(ib_push), .ib_wdata(ib_wdata), .ib_pop(ib_pop), .ib_rdata(ib_rdata),
    .ib_empty(ib_empty), .ib_full(ib_full), .ib_four(ib_four),
    .mbox_set(mbox_set), .mbox_full(mbox_full)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FIFO check FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    ob_push = 0; ob_pop = 0; ib_push = 0; ib_pop = 0;
    ctl_wr = 0; ctl_wdata = '0; mbox_set = '0;
  endtask

  task automatic t_reset();
    eq("R11 ob_empty", 32'(ob_empty), 1);
    eq("R11 ob_four", 32'(ob_four), 0);
    eq("R11 ib_empty", 32'(ib_empty), 1);
    eq("R11 ib_four", 32'(ib_four), 1);
    eq("R11 mbox", 32'(mbox_full), 0);
    eq("R11 ctl_rdata", ctl_rdata, 0);
  endtask

  task automatic t_ob_order();
    for (int k = 1; k <= 5; k++) begin
      ob_push = 1; ob_wdata = 32'hA000_0000 + 32'(k);
      tick();
      eq("R2 ob_empty", 32'(ob_empty), 0);
      eq("R3 ob_four", 32'(ob_four), 32'(k >= 4));
    end
    for (int k = 1; k <= 5; k++) begin
      eq("R1 ob order", ob_rdata, 32'hA000_0000 + 32'(k));
      ob_pop = 1;
      tick();
      eq("R3 ob_four drain", 32'(ob_four), 32'(5 - k >= 4));
    end
    eq("R2 ob empty after drain", 32'(ob_empty), 1);
  endtask

  task automatic t_ib_full();
    for (int k = 1; k <= DEPTH; k++) begin
      ib_push = 1; ib_wdata = 32'hB000_0000 + 32'(k);
      tick();
      eq("R4 ib_four", 32'(ib_four), 32'(DEPTH - k >= 4));
      eq("R2 ib_full", 32'(ib_full), 32'(k == DEPTH));
    end
    ib_push = 1; ib_wdata = 32'hDEAD_BEEF;
    tick();
    eq("R5 full stays", 32'(ib_full), 1);
    for (int k = 1; k <= DEPTH; k++) begin
      eq("R5 R1 ib data after overflow", ib_rdata, 32'hB000_0000 + 32'(k));
      ib_pop = 1;
      tick();
    end
    eq("R2 ib empty", 32'(ib_empty), 1);
    ib_pop = 1;
    tick();
    eq("R5 empty pop ignored", 32'(ib_empty), 1);
    ib_push = 1; ib_wdata = 32'h1234_5678;
    tick();
    eq("R5 data after underflow", ib_rdata, 32'h1234_5678);
    ib_pop = 1;
    tick();
  endtask

  task automatic t_ob_clear();
    for (int k = 0; k < 3; k++) begin
      ob_push = 1; ob_wdata = 32'hC0 + 32'(k);
      tick();
    end
    for (int k = 0; k < 2; k++) begin
      ib_push = 1; ib_wdata = 32'hD0 + 32'(k);
      tick();
    end
    ctl_wr = 1; ctl_wdata = 32'h0400_0000; ob_push = 1; ob_wdata = 32'hFF;
    tick();
    eq("R6 ob_empty", 32'(ob_empty), 1);
    eq("R6 ob_four", 32'(ob_four), 0);
    eq("R6 ib untouched", 32'(ib_empty), 0);
    eq("R6 ib data kept", ib_rdata, 32'hD0);
    ob_push = 1; ob_wdata = 32'h77;
    tick();
    eq("R6 pointers reset", ob_rdata, 32'h77);
    ob_pop = 1;
    tick();
  endtask

  task automatic t_ib_clear();
    for (int k = 0; k < DEPTH - 2; k++) begin
      ib_push = 1; ib_wdata = 32'hE0 + 32'(k);
      tick();
    end
    eq("R2 ib full", 32'(ib_full), 1);
    eq("R4 ib_four full", 32'(ib_four), 0);
    ctl_wr = 1; ctl_wdata = 32'h0200_0000; ib_pop = 1;
    tick();
    eq("R7 ib_empty", 32'(ib_empty), 1);
    eq("R7 ib_full", 32'(ib_full), 0);
    eq("R7 ib_four", 32'(ib_four), 1);
  endtask

  task automatic t_mbox();
    mbox_set = 4'b0101;
    tick();
    eq("R8 set", 32'(mbox_full), 32'h5);
    mbox_set = 4'b1000; ctl_wr = 1; ctl_wdata = 32'h0800_0000;
    tick();
    eq("R8 clear wins", 32'(mbox_full), 0);
    mbox_set = 4'b0010;
    tick();
    eq("R8 set again", 32'(mbox_full), 32'h2);
    ctl_wr = 1; ctl_wdata = 32'h0800_0000;
    tick();
    eq("R8 clear", 32'(mbox_full), 0);
  endtask

  task automatic t_ctl();
    ctl_wr = 1; ctl_wdata = 32'hFFFF_FFFF;
    tick();
    eq("R10 R9 rdata", ctl_rdata, 32'h1000_0000);
    eq("R9 xfer_cnt_en", 32'(xfer_cnt_en), 1);
    ctl_wr = 1; ctl_wdata = 32'h0E00_0000;
    tick();
    eq("R10 strobes read zero", ctl_rdata, 0);
    eq("R9 xfer cleared", 32'(xfer_cnt_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ob_order();
    t_ib_full();
    t_ob_clear();
    t_ib_clear();
    t_mbox();
    t_ctl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("Watchdog FAIL all: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule